// File: doc/BRIEF.md
# Fork-Join Handshake Sequencer

This controller runs a three-step job across worker units that each speak a simple start/busy handshake. A one-cycle trigger pulse opens a job: the controller raises the start request of every parallel worker at once and holds it until each of them reports busy. It then waits for all of them to go quiet. After that it requests the single follow-on worker, waits for that worker to report busy, and then waits for it to finish before going back to idle.

The controller has no data path. Each start request is decoded from the controller state alone, so the request lines are glitch-free. By default they are also retimed through a flop that is loaded from the next state, which keeps the same cycle timing. A trigger that arrives while a job is running is dropped. Nothing is queued. The current state is brought out on a port so that it can be observed.

The number of parallel workers is a parameter, set to two by default. A worker that has not raised busy before another worker finishes leaves the controller waiting in its launch state until reset. The user of the block must avoid that case.

Top module: `hsq_ctrl`

## Requirements
- R1: A synchronous reset, whether applied at start-up or in the middle of a job, puts the state into idle on the next clock edge and drives every start output low.
- R2: In idle, a clock edge with `tick` high moves the state to fork. Without `tick` the state stays in idle.
- R3: In fork, every bit of `start_par` is high and `start_seq` is low. The state moves to join only on an edge where every bit of `busy_par` is high. Otherwise it stays in fork.
- R4: In join, the state stays while any bit of `busy_par` is high. It moves to kick on the first edge where all bits of `busy_par` are low.
- R5: In kick, `start_seq` is high and `start_par` is all low. The state stays in kick until an edge with `busy_seq` high, which moves it to drain.
- R6: In drain, the state stays while `busy_seq` is high. It returns to idle on the first edge where `busy_seq` is low.
- R7: A `tick` seen in any state other than idle has no effect. A job produces exactly one entry into fork, and no second job follows it.
- R8: In idle, join and drain, all start outputs are low.
- R9: If some parallel worker never raises busy, the controller remains in fork with `start_par` held high for as long as that lasts.
- R10: `state_o` encodes the states as idle=0, fork=1, join=2, kick=3, drain=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Job trigger pulse |
| busy_par | input | NPAR | Busy flags of the parallel workers |
| busy_seq | input | 1 | Busy flag of the follow-on worker |
| start_par | output | NPAR | Start requests to the parallel workers |
| start_seq | output | 1 | Start request to the follow-on worker |
| state_o | output | 3 | Current controller state |

## Verification
Jobs are run with equal parallel latencies, with the first worker slower than the second, with the second slower than the first, and with one-cycle latencies everywhere. These cases separate a join that waits for all workers from one that waits only for the first, and they show whether the busy-confirm step holds when busy lasts for a single cycle. A run with triggers injected during the join and drain phases tells a dropped trigger apart from a queued one. A run with one parallel worker disabled shows the stall in fork, and a reset applied in the middle of that stall shows that the controller recovers.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
   localparam int STATE_W = 3;
   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_FORK  = 3'd1,
      ST_JOIN  = 3'd2,
      ST_KICK  = 3'd3,
      ST_DRAIN = 3'd4
   } hsq_state_e;
endpackage

// File: rtl/hsq_join.sv
module hsq_join #(
   parameter int NPAR = 2
) (
   input  logic [NPAR-1:0] busy_par,
   output logic            all_busy,
   output logic            any_busy
);
   generate
      if (NPAR == 1) begin : g_single
         assign all_busy = busy_par[0];
         assign any_busy = busy_par[0];
      end else begin : g_multi
         assign all_busy = &busy_par;
         assign any_busy = |busy_par;
      end
   endgenerate
endmodule

// File: rtl/hsq_fsm.sv
module hsq_fsm
   import hsq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       all_busy,
   input  logic       any_busy,
   input  logic       busy_seq,
   output hsq_state_e state_q,
   output hsq_state_e state_d
);
   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (tick)      state_d = ST_FORK;
         ST_FORK:  if (all_busy)  state_d = ST_JOIN;
         ST_JOIN:  if (!any_busy) state_d = ST_KICK;
         ST_KICK:  if (busy_seq)  state_d = ST_DRAIN;
         ST_DRAIN: if (!busy_seq) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end
endmodule

// File: rtl/hsq_start_dec.sv
module hsq_start_dec
   import hsq_pkg::*;
#(
   parameter int NPAR = 2
) (
   input  hsq_state_e      state,
   output logic [NPAR-1:0] start_par,
   output logic            start_seq
);
   assign start_par = {NPAR{state == ST_FORK}};
   assign start_seq = (state == ST_KICK);
endmodule

// File: rtl/hsq_ctrl.sv
module hsq_ctrl
   import hsq_pkg::*;
#(
   parameter int NPAR      = 2,
   parameter bit REG_START = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [NPAR-1:0]    busy_par,
   input  logic               busy_seq,
   output logic [NPAR-1:0]    start_par,
   output logic               start_seq,
   output logic [STATE_W-1:0] state_o
);
   generate
      if (NPAR < 1) begin : g_bad_npar
         $error("hsq_ctrl: NPAR must be at least 1");
      end
   endgenerate

   logic       all_busy;
   logic       any_busy;
   hsq_state_e state_q;
   hsq_state_e state_d;

   hsq_join #(.NPAR(NPAR)) u_join (
      .busy_par (busy_par),
      .all_busy (all_busy),
      .any_busy (any_busy)
   );

   hsq_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .all_busy (all_busy),
      .any_busy (any_busy),
      .busy_seq (busy_seq),
      .state_q  (state_q),
      .state_d  (state_d)
   );

   generate
      if (REG_START) begin : g_reg
         logic [NPAR-1:0] sp_d, sp_q;
         logic            sc_d, sc_q;
         hsq_start_dec #(.NPAR(NPAR)) u_dec (
            .state     (state_d),
            .start_par (sp_d),
            .start_seq (sc_d)
         );
         always_ff @(posedge clk) begin
            if (rst) begin
               sp_q <= '0;
               sc_q <= 1'b0;
            end else begin
               sp_q <= sp_d;
               sc_q <= sc_d;
            end
         end
         assign start_par = sp_q;
         assign start_seq = sc_q;
      end else begin : g_comb
         hsq_start_dec #(.NPAR(NPAR)) u_dec (
            .state     (state_q),
            .start_par (start_par),
            .start_seq (start_seq)
         );
      end
   endgenerate

   assign state_o = state_q;
endmodule

// File: rtl/hsq_ctrl_chk.sv
module hsq_ctrl_chk #(
   parameter int NPAR = 2
) (
   input logic            clk,
   input logic            rst,
   input logic            tick,
   input logic [NPAR-1:0] busy_par,
   input logic            busy_seq,
   input logic [NPAR-1:0] start_par,
   input logic            start_seq,
   input logic [2:0]      state_o
);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (state_o == 3'd0 && start_par == '0 && !start_seq));

   // R2
   idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd0 && tick) |=> state_o == 3'd1);

   // R3
   fork_drive_chk: assert property (@(posedge clk) disable iff (rst)
      state_o == 3'd1 |-> (&start_par && !start_seq));

   // R3
   fork_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd1 && !(&busy_par)) |=> state_o == 3'd1);

   // R4
   join_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd2 && busy_par == '0) |=> state_o == 3'd3);

   // R5
   kick_drive_chk: assert property (@(posedge clk) disable iff (rst)
      state_o == 3'd3 |-> (start_seq && start_par == '0));

   // R6
   drain_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd4 && !busy_seq) |=> state_o == 3'd0);

   // R7
   no_refork_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4) |=> state_o != 3'd1);

   // R8
   quiet_start_chk: assert property (@(posedge clk) disable iff (rst)
      (state_o == 3'd0 || state_o == 3'd2 || state_o == 3'd4)
         |-> (start_par == '0 && !start_seq));

   // R10
   legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      state_o <= 3'd4);
endmodule

bind hsq_ctrl hsq_ctrl_chk #(.NPAR(NPAR)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tick      (tick),
   .busy_par  (busy_par),
   .busy_seq  (busy_seq),
   .start_par (start_par),
   .start_seq (start_seq),
   .state_o   (state_o)
);

// File: tb/hsq_ctrl_test.sv
`timescale 1ns/1ps
module hsq_worker_model (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  int   lat,
   input  logic start,
   output logic busy
);
   int cnt;
   always @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         cnt  <= 0;
      end else if (!busy && start && en) begin
         busy <= 1'b1;
         cnt  <= lat;
      end else if (busy) begin
         if (cnt <= 1) busy <= 1'b0;
         cnt <= cnt - 1;
      end
   end
endmodule

module hsq_ctrl_test;
   localparam int NPAR = 2;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            tick = 1'b0;
   logic [NPAR-1:0] busy_par;
   logic            busy_seq;
   logic [NPAR-1:0] start_par;
   logic            start_seq;
   logic [2:0]      state_o;

   int  lat_a = 2, lat_b = 2, lat_c = 2;
   logic en_b = 1'b1;
   int  checks = 0, errors = 0, cycles = 0, forks = 0;
   logic [2:0] last_state = 3'd0;
   logic [2:0] ref_state = 3'd0;

   always #2.5 clk = ~clk;

   hsq_ctrl #(.NPAR(NPAR)) uut (
      .clk(clk), .rst(rst), .tick(tick), .busy_par(busy_par), .busy_seq(busy_seq),
      .start_par(start_par), .start_seq(start_seq), .state_o(state_o)
   );

   hsq_worker_model u_wa (.clk(clk), .rst(rst), .en(1'b1), .lat(lat_a), .start(start_par[0]), .busy(busy_par[0]));
   hsq_worker_model u_wb (.clk(clk), .rst(rst), .en(en_b), .lat(lat_b), .start(start_par[1]), .busy(busy_par[1]));
   hsq_worker_model u_wc (.clk(clk), .rst(rst), .en(1'b1), .lat(lat_c), .start(start_seq), .busy(busy_seq));

   // reference sequencer built from the requirements
   always @(posedge clk) begin
      if (rst) ref_state <= 3'd0;
      else case (ref_state)
         3'd0: if (tick) ref_state <= 3'd1;
         3'd1: if (&busy_par) ref_state <= 3'd2;
         3'd2: if (busy_par == '0) ref_state <= 3'd3;
         3'd3: if (busy_seq) ref_state <= 3'd4;
         3'd4: if (!busy_seq) ref_state <= 3'd0;
         default: ref_state <= 3'd0;
      endcase
   end

   always @(negedge clk) begin
      if (state_o == 3'd1 && last_state != 3'd1) forks++;
      last_state = state_o;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 50000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // compare one cycle against the reference (R3/R4/R5/R6/R10 state, R8 starts)
   task automatic cmp(input string tag);
      logic [NPAR-1:0] ep;
      @(negedge clk);
      ep = (ref_state == 3'd1) ? '1 : '0;
      chk(state_o == ref_state, {tag, " R10 state"}, state_o, ref_state);
      chk(start_par == ep, {tag, " R8 start_par"}, start_par, ep);
      chk(start_seq == (ref_state == 3'd3), {tag, " R8 start_seq"}, start_seq, ref_state == 3'd3);
   endtask

   task automatic t_reset;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(state_o == 3'd0, "R1 reset state", state_o, 0);
      chk(start_par == '0 && !start_seq, "R1 reset starts", {start_par, start_seq}, 0);
      rst = 1'b0;
   endtask

   task automatic t_job(input int la, input int lb, input int lc, input bit extra, input string tag);
      int f0;
      lat_a = la; lat_b = lb; lat_c = lc;
      f0 = forks;
      tick = 1'b1;
      cmp(tag);
      tick = 1'b0;
      for (int i = 0; i < 300; i++) begin
         tick = extra && (i == 3 || i == 8 || i == 12);
         cmp(tag);
         if (ref_state == 3'd0 && i > 1) break;
      end
      tick = 1'b0;
      repeat (4) cmp(tag);
      chk(state_o == 3'd0, {tag, " R6 back to idle"}, state_o, 0);
      chk(forks - f0 == 1, {tag, " R7 single job"}, forks - f0, 1);
   endtask

   task automatic t_idle_hold;
      repeat (5) cmp("idle R2");
      chk(state_o == 3'd0, "R2 no tick stays idle", state_o, 0);
   endtask

   task automatic t_stall;
      en_b = 1'b0; lat_a = 2;
      tick = 1'b1;
      cmp("stall");
      tick = 1'b0;
      repeat (25) cmp("stall R9");
      chk(state_o == 3'd1, "R9 stalled in fork", state_o, 1);
      chk(&start_par, "R9 start held", start_par, 3);
      rst = 1'b1;
      @(negedge clk);
      chk(state_o == 3'd0, "R1 mid-job reset state", state_o, 0);
      chk(start_par == '0 && !start_seq, "R1 mid-job reset starts", {start_par, start_seq}, 0);
      rst = 1'b0;
      en_b = 1'b1;
      repeat (2) cmp("post reset");
   endtask

   initial begin
      t_reset();
      t_idle_hold();
      t_job(3, 3, 2, 1'b0, "equal R3");
      t_job(6, 2, 3, 1'b0, "a slow R4");
      t_job(2, 7, 1, 1'b0, "b slow R4");
      t_job(1, 1, 1, 1'b0, "unit R5");
      t_job(4, 5, 6, 1'b1, "tick busy R7");
      t_stall();
      t_job(2, 3, 4, 1'b0, "recover R6");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule